// File: doc/BRIEF.md
# Port Change Monitor with Held-Off Latched Interrupt

This block watches a byte of general-purpose port pins for level changes. The block's inputs pass through a two-stage synchronizer. It then compares each monitored bit against a stored snapshot. A difference sets a sticky per-bit change flag and pulls an active-low interrupt. The flag stays set even if the pin returns to its old level before anyone looks. A pin counts as an input only while its open-drain output latch is 1. Pins the block itself drives low are ignored. A pin whose latch has just been raised is also ignored for a short settle window, so a bus write that changes a pin's level does not raise an interrupt.

A serial-bus controller sits beside the block and gives it three things. The first is a strobe at every address acknowledge and at every new port-data byte of a multi-byte read. The second is a level that is high while a transaction is on the wire. The third is a STOP strobe, with a separate bus-reset strobe. Each snapshot strobe reloads the snapshot from the synchronized pins and clears the flags. It also captures the flags held just before the clear, so the controller can return them as the flag byte. From the strobe until the STOP, the interrupt is held off. Changes seen in that window are still recorded, and they pull the interrupt once the bus is released.

Top module: `port_change_monitor`

## Requirements
- R1: While rst_ni is low, int_no is 1, flags_o is 0 and snap_o is 0.
- R2: Each pin passes through two flops before comparison. A monitored bit whose synchronized level differs from its snapshot bit sets its change flag on that edge. The flag stays set after the pin reverts, until the next snapshot strobe.
- R3: int_no is registered. It goes low on the same edge that a flag becomes set, unless the hold-off is active or bus_busy_i is high. A pin change therefore shows on int_no at the third rising edge after it.
- R4: On an edge with snap_i high, the snapshot (snap_o) is loaded from the synchronized pins and the flags are cleared. flags_o is loaded with the flags as they stood, including any difference detected on that edge. int_no is 1 after that edge.
- R5: After snap_i, int_no stays 1 until stop_i or bus_rst_i. Changes in between still set flags, and int_no goes low on the release edge when any flag is set.
- R6: Every further snap_i in a transaction reloads the snapshot and clears the flags again. flags_o then reports only the changes seen since the previous strobe.
- R7: A bit whose latch_i is 0 never sets a flag. Its snapshot bit follows the synchronized pin every cycle.
- R8: For SETTLE_CYC edges after a latch_i bit rises from 0 to 1, and after reset, that bit is not monitored and its snapshot bit follows the synchronized pin. A write that releases a pin high therefore raises no flag.
- R9: While bus_busy_i is high, int_no is held at 1 from the next edge on. The flags are kept.
- R10: bus_rst_i ends the hold-off like a STOP. It leaves the flags, flags_o and snap_o unchanged and never deasserts an asserted int_no.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| port_i | input | WIDTH | Raw pin levels, asynchronous |
| latch_i | input | WIDTH | Open-drain output latch, 1 = released/input |
| snap_i | input | 1 | Snapshot strobe from the bus controller (address ack, next port-data byte) |
| stop_i | input | 1 | STOP condition strobe |
| bus_rst_i | input | 1 | Bus reset strobe, ends a transaction |
| bus_busy_i | input | 1 | High while a bus transaction is in progress |
| int_no | output | 1 | Active-low latched interrupt |
| flags_o | output | WIDTH | Flags captured at the last snapshot strobe |
| snap_o | output | WIDTH | Current snapshot (port data sent to the host) |

## Verification
A corrupted snapshot bit shows up as a false flag and an int_no fall within three edges of the fault. The same fault reaches flags_o at the next strobe. A flag that is lost or cleared early shows as a missing or wrong bit in flags_o at the next strobe. A hold-off that ends early or ends late shows up on int_no on the exact edge where the reference model expects the change. Settle-window and masking errors show as an interrupt after a write that only changed latch levels.

// File: rtl/ptd_pkg.sv
package ptd_pkg;
  typedef struct packed {
    logic snap;
    logic stop;
    logic abort;
    logic busy;
  } ptd_bus_ev_t;
endpackage

// File: rtl/ptd_sync.sv
module ptd_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) st_q[k] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) st_q[k] <= st_q[k-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ptd_settle.sv
module ptd_settle #(
  parameter int unsigned WIDTH      = 8,
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] latch_i,
  output logic [WIDTH-1:0] mon_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC);

  logic [WIDTH-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else         lat_q <= latch_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [CNT_W-1:0] cnt_q;
    logic             rise;

    assign rise     = latch_i[i] & ~lat_q[i];
    assign mon_o[i] = latch_i[i] & (cnt_q == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (rise)          cnt_q <= CNT_LOAD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    // R8: freshly released pin is blind on the next cycle
    a_r8_quiet_after_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise |=> !mon_o[i]);
  end
endmodule

// File: rtl/ptd_tracker.sv
module ptd_tracker #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] mon_i,
  input  logic             snap_i,
  output logic [WIDTH-1:0] snap_o,
  output logic [WIDTH-1:0] cap_o,
  output logic             flag_any_d_o
);
  logic [WIDTH-1:0] snap_q, snap_d;
  logic [WIDTH-1:0] flags_q, flags_d;
  logic [WIDTH-1:0] cap_q, cap_d;
  logic [WIDTH-1:0] diff;

  always_comb begin
    diff    = (sync_i ^ snap_q) & mon_i;
    flags_d = flags_q | diff;
    cap_d   = cap_q;
    // unmonitored bits follow the pin so they re-arm without a false change
    snap_d  = (snap_q & mon_i) | (sync_i & ~mon_i);
    if (snap_i) begin
      cap_d   = flags_q | diff;
      flags_d = '0;
      snap_d  = sync_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '0;
      flags_q <= '0;
      cap_q   <= '0;
    end else begin
      snap_q  <= snap_d;
      flags_q <= flags_d;
      cap_q   <= cap_d;
    end
  end

  assign snap_o       = snap_q;
  assign cap_o        = cap_q;
  assign flag_any_d_o = |flags_d;

  a_r2_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  a_r4_flags_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> (flags_q == '0));

  a_r7_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> ((flags_q & ~$past(flags_q) & ~$past(mon_i)) == '0));

  a_r4_capture_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(cap_q));
endmodule

// File: rtl/ptd_irq.sv
module ptd_irq
  import ptd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  ptd_bus_ev_t ev_i,
  input  logic        flag_any_d_i,
  output logic        int_no
);
  logic hold_q, hold_d;
  logic int_q, int_d;

  always_comb begin
    hold_d = hold_q;
    if (ev_i.stop || ev_i.abort) hold_d = 1'b0;
    else if (ev_i.snap)          hold_d = 1'b1;
    int_d = flag_any_d_i & ~hold_d & ~ev_i.busy;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      int_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      int_q  <= int_d;
    end
  end

  assign int_no = ~int_q;

  a_r4_int_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i.snap && !ev_i.stop && !ev_i.abort) |=> !int_q);

  a_r5_held_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !ev_i.stop && !ev_i.abort) |=> !int_q);

  a_r9_busy_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.busy |=> !int_q);

  a_r10_abort_keeps_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i.abort && int_q && !ev_i.snap && !ev_i.busy) |=> int_q);
endmodule

// File: rtl/port_change_monitor.sv
module port_change_monitor
  import ptd_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SETTLE_CYC  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] port_i,
  input  logic [WIDTH-1:0] latch_i,
  input  logic             snap_i,
  input  logic             stop_i,
  input  logic             bus_rst_i,
  input  logic             bus_busy_i,
  output logic             int_no,
  output logic [WIDTH-1:0] flags_o,
  output logic [WIDTH-1:0] snap_o
);
  logic [WIDTH-1:0] sync_w;
  logic [WIDTH-1:0] mon_w;
  logic             flag_any_d;
  ptd_bus_ev_t      ev;

  assign ev = '{snap: snap_i, stop: stop_i, abort: bus_rst_i, busy: bus_busy_i};

  ptd_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (port_i),
    .q_o   (sync_w)
  );

  ptd_settle #(.WIDTH(WIDTH), .SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .latch_i(latch_i),
    .mon_o  (mon_w)
  );

  ptd_tracker #(.WIDTH(WIDTH)) u_tracker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (sync_w),
    .mon_i       (mon_w),
    .snap_i      (snap_i),
    .snap_o      (snap_o),
    .cap_o       (flags_o),
    .flag_any_d_o(flag_any_d)
  );

  ptd_irq u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ev_i        (ev),
    .flag_any_d_i(flag_any_d),
    .int_no      (int_no)
  );

  a_r10_abort_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rst_i && !snap_i) |=> ($stable(flags_o) && $stable(snap_o & latch_i & $past(latch_i))));
endmodule

// File: tb/port_change_monitor_bench.sv
module port_change_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int SETTLE     = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] latch = '1;
  logic [W-1:0] ext   = '1;
  logic         snap_i = 1'b0, stop_i = 1'b0, bus_rst_i = 1'b0, bus_busy_i = 1'b0;
  logic [W-1:0] port_w;
  logic         int_no;
  logic [W-1:0] flags_o, snap_o;

  int    n_run = 0, n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  assign port_w = latch & ext;  // open-drain pin with external pull-up

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  port_change_monitor #(.WIDTH(W), .SYNC_STAGES(2), .SETTLE_CYC(SETTLE)) u_port_change_monitor (
    .clk_i(clk_i), .rst_ni(rst_ni), .port_i(port_w), .latch_i(latch),
    .snap_i(snap_i), .stop_i(stop_i), .bus_rst_i(bus_rst_i), .bus_busy_i(bus_busy_i),
    .int_no(int_no), .flags_o(flags_o), .snap_o(snap_o)
  );

  // behavioural reference
  logic [W-1:0] hist [$];
  int           quiet [W];
  logic [W-1:0] m_prev_latch = '0, m_snap = '0, m_flags = '0, m_cap = '0;
  bit           m_hold = 0, m_int = 0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      hist.delete();
      for (int b = 0; b < W; b++) quiet[b] = 0;
      m_prev_latch = '0; m_snap = '0; m_flags = '0; m_cap = '0;
      m_hold = 0; m_int = 0;
    end else begin
      logic [W-1:0] seen;
      seen = (hist.size() >= 2) ? hist[hist.size()-2] : '0;
      if (snap_i) m_cap = '0;
      for (int b = 0; b < W; b++) begin
        bit watching, changed;
        watching = latch[b] && (quiet[b] == 0);
        changed  = watching && (seen[b] != m_snap[b]);
        if (snap_i) begin
          m_cap[b]   = m_flags[b] | changed;
          m_flags[b] = 1'b0;
          m_snap[b]  = seen[b];
        end else begin
          if (changed)   m_flags[b] = 1'b1;
          if (!watching) m_snap[b]  = seen[b];
        end
        if (latch[b] && !m_prev_latch[b]) quiet[b] = SETTLE;
        else if (quiet[b] > 0)            quiet[b] = quiet[b] - 1;
      end
      m_prev_latch = latch;
      if (stop_i || bus_rst_i) m_hold = 0;
      else if (snap_i)         m_hold = 1;
      m_int = (m_flags != 0) && !m_hold && !bus_busy_i;
      hist.push_back(port_w);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare against the model on every cycle, away from the rising edge
  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      check(cur_req, "int_no",  {{(W-1){1'b0}}, int_no}, {{(W-1){1'b0}}, ~m_int});
      check(cur_req, "flags_o", flags_o, m_cap);
      check(cur_req, "snap_o",  snap_o,  m_snap);
    end
  endtask

  task automatic pulse_snap();  snap_i = 1;    cyc(1); snap_i = 0;    endtask
  task automatic pulse_stop();  stop_i = 1;    cyc(1); stop_i = 0;    endtask
  task automatic pulse_brst();  bus_rst_i = 1; cyc(1); bus_rst_i = 0; endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    repeat (3) @(negedge clk_i);
    check("R1", "int_no reset",  {7'd0, int_no}, 8'h01);
    check("R1", "flags reset",   flags_o, 8'h00);
    check("R1", "snap reset",    snap_o,  8'h00);
    rst_ni = 1;
    cur_req = "R8";
    cyc(10);
    check("R8", "snap tracks after reset", snap_o, 8'hFF);
    check("R8", "no int after settle",     {7'd0, int_no}, 8'h01);

    // R2/R3 transient on bit 3
    cur_req = "R2";
    ext[3] = 0; cyc(2); ext[3] = 1;
    cur_req = "R3";
    cyc(6);
    check("R3", "int low after glitch", {7'd0, int_no}, 8'h00);
    check("R2", "flags_o not yet captured", flags_o, 8'h00);

    // R4 read access
    cur_req = "R4";
    bus_busy_i = 1; cyc(1);
    pulse_snap(); cyc(1);
    check("R4", "captured glitch flag", flags_o, 8'h08);
    check("R4", "int released", {7'd0, int_no}, 8'h01);

    // R5 change during read, released by STOP
    cur_req = "R5";
    ext[5] = 0; cyc(6);
    check("R5", "int held during read", {7'd0, int_no}, 8'h01);
    bus_busy_i = 0; pulse_stop(); cyc(2);
    check("R5", "int after STOP", {7'd0, int_no}, 8'h00);

    // R6 multi-byte read
    cur_req = "R6";
    bus_busy_i = 1; pulse_snap(); cyc(1);
    check("R6", "first strobe flags", flags_o, 8'h20);
    ext[0] = 0; cyc(6);
    pulse_snap(); cyc(1);
    check("R6", "second strobe flags", flags_o, 8'h01);
    cyc(4);
    pulse_snap(); cyc(1);
    check("R6", "third strobe flags", flags_o, 8'h00);
    bus_busy_i = 0; pulse_stop(); cyc(4);
    check("R6", "no int after quiet read", {7'd0, int_no}, 8'h01);

    // R8 write that drives low then releases bit 6
    cur_req = "R8";
    bus_busy_i = 1; pulse_snap();
    latch[6] = 0; cyc(4);
    latch[6] = 1; cyc(8);
    bus_busy_i = 0; pulse_stop(); cyc(4);
    check("R8", "no int after write", {7'd0, int_no}, 8'h01);
    bus_busy_i = 1; pulse_snap(); cyc(1);
    check("R8", "no flag from write", flags_o, 8'h00);
    bus_busy_i = 0; pulse_stop(); cyc(2);

    // R7 masked bit 2 toggling
    cur_req = "R7";
    latch[2] = 0; cyc(6);
    for (int k = 0; k < 6; k++) begin
      ext[2] = ~ext[2]; cyc(3);
    end
    check("R7", "no int from masked bit", {7'd0, int_no}, 8'h01);
    ext[2] = 1; latch[2] = 1; cyc(8);
    bus_busy_i = 1; pulse_snap(); cyc(1);
    check("R7", "no flag from masked bit", flags_o, 8'h00);
    bus_busy_i = 0; pulse_stop(); cyc(2);

    // R9 busy gate
    cur_req = "R9";
    bus_busy_i = 1; ext[1] = 0; cyc(6);
    check("R9", "int held by busy", {7'd0, int_no}, 8'h01);
    bus_busy_i = 0; cyc(2);
    check("R9", "int after busy drops", {7'd0, int_no}, 8'h00);

    // R10 bus reset keeps int and flags, ends hold-off
    cur_req = "R10";
    pulse_brst(); cyc(2);
    check("R10", "int kept by bus reset", {7'd0, int_no}, 8'h00);
    check("R10", "flags_o kept", flags_o, 8'h00);
    bus_busy_i = 1; pulse_snap(); cyc(1);
    check("R10", "flag survived bus reset", flags_o, 8'h02);
    bus_busy_i = 0; ext[1] = 1; cyc(6);
    check("R10", "held during transaction", {7'd0, int_no}, 8'h01);
    pulse_brst(); cyc(2);
    check("R10", "bus reset ends hold-off", {7'd0, int_no}, 8'h00);
    cyc(4);

    finish_run();
  end
endmodule